// File: doc/BRIEF.md
# Self-Timed Imager Cycle Controller

This block paces a self-timed image sensor and the synchronous logic behind it. Each period begins with the sensor held in reset. Reset is held until the array reports that it has been reset far enough. The block then opens a long watching phase, which lasts until the array reports that a stable image has formed. A short cycling phase of fixed length follows. During that phase the image is latched and the sensor is reset again. Every period of the two phase outputs therefore matches exactly one decision of the sensor. The period depends only on how long the sensor takes, and no assumption is made about its speed.

The controller runs on a fast free-running system clock. The two sensor indications are asynchronous, so each passes through its own flop synchronizer before use. All outputs come straight from flops, so the phase lines never glitch. The two phases are never high together, and a programmable gap of low cycles separates them. A wrapping counter records how many periods have been completed.

Top module: `imgcyc_top`

## Requirements
- R1: The long and short phases are never high in the same cycle. Between the fall of either phase and the next rise of the other, both stay low for at least GAP_LEN clocks.
- R2: The long phase rises GAP_LEN clocks after the controller leaves its reset-holding state. It then stays high for as long as the synchronized DONE stays low, however long that takes. It falls on the first clock edge at which the synchronized DONE is high, which is SYNC_STAGES+1 edges after done_in rises.
- R3: sensor_rst is high while the controller waits for READY and throughout the short phase, and low otherwise. In the waiting state it falls on the first edge at which the synchronized READY is high, which is SYNC_STAGES+1 edges after ready_in rises.
- R4: Each short phase lasts exactly SHORT_LEN clocks. It begins GAP_LEN clocks after the long phase falls, and the controller returns to the reset-holding state when it ends.
- R5: latch_img is high for exactly one clock per period: the first clock of the short phase.
- R6: done_in has no effect outside the long phase, and ready_in has no effect outside the reset-holding state.
- R7: cycle_count increases by one, modulo 2^CNT_W, on the edge at which the short phase falls. It does not change on any other edge.
- R8: While rst_n is low, sensor_rst is 1, the two phases and latch_img are 0, and cycle_count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ready_in | input | 1 | Asynchronous indication that the sensor array is fully reset |
| done_in | input | 1 | Asynchronous indication that a stable image exists |
| sensor_rst | output | 1 | Reset line to the sensor array |
| ph_long | output | 1 | Unbounded watching phase for downstream logic |
| ph_short | output | 1 | Bounded cycling phase for downstream logic |
| latch_img | output | 1 | One-clock strobe that captures the image |
| cycle_count | output | CNT_W | Number of completed periods, wrapping |

## Verification
The bench builds the block with SHORT_LEN=3 and GAP_LEN=2, so every state uses a counter of more than one step. With CNT_W=4, the period counter wraps after only sixteen periods, which brings the wrap within reach of a short run. Directed stretches hold the long phase and the reset-holding state for hundreds of clocks while the ignored input toggles. Pseudo-random stretches at several input densities then cover single-clock pulses and back-to-back periods.

// File: rtl/imgcyc_pkg.sv
package imgcyc_pkg;
  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_GAP_W  = 3'd1,
    ST_WATCH  = 3'd2,
    ST_GAP_S  = 3'd3,
    ST_SHORT  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/imgcyc_sync.sv
module imgcyc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain <= {chain[STAGES-2:0], d};
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/imgcyc_seq.sv
module imgcyc_seq
  import imgcyc_pkg::*;
#(
  parameter int SHORT_LEN = 4,
  parameter int GAP_LEN   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_s,
  input  logic done_s,
  output logic rst_o,
  output logic long_o,
  output logic short_o,
  output logic latch_o,
  output logic cyc_done_o
);
  localparam int MAXL = (SHORT_LEN > GAP_LEN) ? SHORT_LEN : GAP_LEN;
  localparam int CW   = $clog2(MAXL + 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_LEN - 1);
  localparam logic [CW-1:0] GAP_LAST   = CW'(GAP_LEN - 1);

  seq_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rst_q, long_q, short_q, latch_q;
  logic          rst_d, long_d, short_d, latch_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    cyc_done_o = 1'b0;
    unique case (state_q)
      ST_RESET: begin
        if (ready_s) begin
          state_d = ST_GAP_W;
          cnt_d   = '0;
        end
      end
      ST_GAP_W: begin
        if (cnt_q == GAP_LAST) begin
          state_d = ST_WATCH;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WATCH: begin
        if (done_s) begin
          state_d = ST_GAP_S;
          cnt_d   = '0;
        end
      end
      ST_GAP_S: begin
        if (cnt_q == GAP_LAST) begin
          state_d = ST_SHORT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SHORT: begin
        if (cnt_q == SHORT_LAST) begin
          state_d    = ST_RESET;
          cnt_d      = '0;
          cyc_done_o = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_RESET;
        cnt_d   = '0;
      end
    endcase
  end

  always_comb begin
    rst_d   = (state_d == ST_RESET) || (state_d == ST_SHORT);
    long_d  = (state_d == ST_WATCH);
    short_d = (state_d == ST_SHORT);
    latch_d = (state_d == ST_SHORT) && (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RESET;
      cnt_q   <= '0;
      rst_q   <= 1'b1;
      long_q  <= 1'b0;
      short_q <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rst_q   <= rst_d;
      long_q  <= long_d;
      short_q <= short_d;
      latch_q <= latch_d;
    end
  end

  assign rst_o   = rst_q;
  assign long_o  = long_q;
  assign short_o = short_q;
  assign latch_o = latch_q;

  logic [CW-1:0] short_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      short_run <= '0;
    end else if (short_q) begin
      short_run <= short_run + 1'b1;
    end else begin
      short_run <= '0;
    end
  end

  AST_GAP_BEFORE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_q) |-> !$past(long_q)); // R1
  AST_GAP_BEFORE_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(long_q) |-> !$past(short_q)); // R1
  AST_WATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (long_q && !done_s) |=> long_q); // R2
  AST_RST_IN_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    short_q |-> rst_q); // R3
  AST_RESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q && !short_q && !ready_s) |=> (rst_q && !long_q)); // R6
  AST_SHORT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(short_q) |-> (short_run == CW'(SHORT_LEN))); // R4
  AST_LATCH_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q |-> $rose(short_q)); // R5
endmodule

// File: rtl/imgcyc_count.sv
module imgcyc_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (en) begin
      q_d = q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_d;
    end
  end
endmodule

// File: rtl/imgcyc_top.sv
module imgcyc_top #(
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_LEN   = 4,
  parameter int GAP_LEN     = 1,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready_in,
  input  logic             done_in,
  output logic             sensor_rst,
  output logic             ph_long,
  output logic             ph_short,
  output logic             latch_img,
  output logic [CNT_W-1:0] cycle_count
);
  logic ready_s, done_s, cyc_done;

  imgcyc_sync #(.STAGES(SYNC_STAGES)) u_sync_ready (
    .clk(clk), .rst_n(rst_n), .d(ready_in), .q(ready_s)
  );

  imgcyc_sync #(.STAGES(SYNC_STAGES)) u_sync_done (
    .clk(clk), .rst_n(rst_n), .d(done_in), .q(done_s)
  );

  imgcyc_seq #(.SHORT_LEN(SHORT_LEN), .GAP_LEN(GAP_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .ready_s(ready_s), .done_s(done_s),
    .rst_o(sensor_rst), .long_o(ph_long), .short_o(ph_short),
    .latch_o(latch_img), .cyc_done_o(cyc_done)
  );

  imgcyc_count #(.W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .en(cyc_done), .q(cycle_count)
  );

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph_long && ph_short)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_short) |-> (cycle_count == $past(cycle_count) + 1'b1)); // R7
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(ph_short) |-> $stable(cycle_count)); // R7
endmodule

// File: tb/tb_imgcyc_top.sv
module tb_imgcyc_top;
  localparam int SYNC  = 2;
  localparam int SHORT = 3;
  localparam int GAP   = 2;
  localparam int CW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ready_in = 1'b0;
  logic done_in = 1'b0;
  logic sensor_rst, ph_long, ph_short, latch_img;
  logic [CW-1:0] cycle_count;

  int vectors = 0;
  int fails = 0;

  imgcyc_top #(.SYNC_STAGES(SYNC), .SHORT_LEN(SHORT), .GAP_LEN(GAP), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .ready_in(ready_in), .done_in(done_in),
    .sensor_rst(sensor_rst), .ph_long(ph_long), .ph_short(ph_short),
    .latch_img(latch_img), .cycle_count(cycle_count)
  );

  always #5 clk = ~clk;

  // Behavioural reference: phase 0 wait ready, 1 gap, 2 watch, 3 gap, 4 short
  int m_ph, m_cnt, m_count;
  bit rq[$];
  bit dq[$];
  bit m_rdy, m_dn;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_count = 0;
      rq = {}; dq = {};
      for (int i = 0; i < SYNC; i++) begin rq.push_back(1'b0); dq.push_back(1'b0); end
    end else begin
      m_rdy = rq[0];
      m_dn  = dq[0];
      case (m_ph)
        0: if (m_rdy) begin m_ph = 1; m_cnt = 0; end
        1, 3: begin
          if (m_cnt == GAP - 1) begin m_ph = m_ph + 1; m_cnt = 0; end
          else m_cnt = m_cnt + 1;
        end
        2: if (m_dn) begin m_ph = 3; m_cnt = 0; end
        default: begin
          if (m_cnt == SHORT - 1) begin
            m_ph = 0; m_cnt = 0; m_count = (m_count + 1) % (1 << CW);
          end else m_cnt = m_cnt + 1;
        end
      endcase
      void'(rq.pop_front()); rq.push_back(ready_in);
      void'(dq.pop_front()); dq.push_back(done_in);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  int low_run = 100;
  bit prev_long = 0, prev_short = 0;

  task automatic compare_all();
    chk("R3 sensor_rst", int'(sensor_rst), int'(m_ph == 0 || m_ph == 4));
    chk("R2 ph_long", int'(ph_long), int'(m_ph == 2));
    chk("R4 ph_short", int'(ph_short), int'(m_ph == 4));
    chk("R5 latch_img", int'(latch_img), int'(m_ph == 4 && m_cnt == 0));
    chk("R7 cycle_count", int'(cycle_count), m_count);
    chk("R1 overlap", int'(ph_long && ph_short), 0);
    if ((ph_long && !prev_long) || (ph_short && !prev_short))
      chk("R1 gap length ok", int'(low_run >= GAP), 1);
    if (!ph_long && !ph_short) low_run++; else low_run = 0;
    prev_long = ph_long; prev_short = ph_short;
  endtask

  task automatic step(input bit r, input bit d);
    @(negedge clk);
    compare_all();
    ready_in = r;
    done_in  = d;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset values
    chk("R8 sensor_rst", int'(sensor_rst), 1);
    chk("R8 ph_long", int'(ph_long), 0);
    chk("R8 ph_short", int'(ph_short), 0);
    chk("R8 latch_img", int'(latch_img), 0);
    chk("R8 cycle_count", int'(cycle_count), 0);
    rst_n = 1'b1;

    // R6: done pulses while waiting for ready have no effect
    for (int i = 0; i < 200; i++) step(1'b0, i[2]);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R6 still resetting", int'(sensor_rst), 1);
    chk("R6 long stays low", int'(ph_long), 0);

    // R3/R2: ready rises, then a long watch while ready toggles (R6)
    step(1'b1, 1'b0);
    for (int i = 0; i < 300; i++) step(i[1], 1'b0);
    chk("R2 long phase unbounded", int'(ph_long), 1);
    chk("R6 ready ignored in watch", int'(sensor_rst), 0);
    // R4/R5/R7: done ends the watch
    step(1'b0, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1);
    chk("R7 first period counted", int'(cycle_count), 1);

    // Back-to-back periods, both inputs held high
    for (int i = 0; i < 400; i++) step(1'b1, 1'b1);

    // Pseudo-random stretches at several densities
    for (int dens = 1; dens <= 4; dens++) begin
      for (int i = 0; i < 2000; i++) begin
        int rv = $urandom_range(0, 7);
        int dv = $urandom_range(0, 7);
        step(rv < dens * 2, dv < dens * 2 - 1);
      end
    end

    // Single-clock pulses
    for (int i = 0; i < 600; i++) step(i % 17 == 0, i % 13 == 0);

    step(1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule